// File: doc/BRIEF.md
# Core Regulator Supervisor

This block is the supervisory controller of a single-output core-voltage buck regulator. It receives digitized comparator results (supply level against two power-on thresholds, enable, soft-start completion, output-in-window, under-voltage, over-voltage, two temperature trip points, a latched over-current request and a flag that marks a commanded voltage transition). From these it decides when the converter may switch, when the power-good pin may be released high, when the low-side switch must be forced on as a crowbar, and when the soft-start ramp must be restarted.

Every flag passes through a synchronizer of `SYNC_STAGES` flops before it is used. A five-state controller (off, soft start, run, latched fault, over-temperature) then sequences the regulator. The outputs are decoded from the controller state and the synchronized flags. All pins are plain level signals; there is no data stream and no handshake.

Top module: `core_supervisor`

## Requirements
- R1: While reset is asserted and right after it, conv_en, pwr_good, crowbar and ss_restart are all low.
- R2: Start-up needs sup_hi_ok high. Once running, the regulator keeps running while sup_lo_ok stays high, even if sup_hi_ok falls. sup_lo_ok low forces the off state from any state.
- R3: Every entry into soft start produces exactly one ss_restart pulse of one clock. During soft start conv_en is high and pwr_good is low.
- R4: pwr_good is high only in the run state, which is reached once ss_done is seen, and only while out_ok is high and ov_trip is low. It falls when out_ok falls and v_slewing is low.
- R5: While v_slewing is high in the run state, pwr_good stays high even if out_ok is low.
- R6: uv_trip in the run state with v_slewing low latches a fault, with conv_en and pwr_good low. uv_trip is ignored while v_slewing is high and throughout soft start.
- R7: ov_trip in the run state drives crowbar high and conv_en and pwr_good low. The crowbar releases as soon as ov_trip clears, and the regulator returns to normal run without latching.
- R8: In the latched-fault state, crowbar follows ov_trip.
- R9: temp_hot shuts the converter off. Operation restarts, through a full soft start, only once temp_cool is high and temp_hot is low.
- R10: oc_req latches a fault that remains after oc_req is removed.
- R11: A latched fault is not cleared while en stays high. It clears only when en goes low then high, or when sup_lo_ok drops and the supply then returns, and each clear leads to a new soft start.
- R12: en low stops the converter from soft start, run or over-temperature. en high again restarts it through soft start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_hi_ok | input | 1 | Supply above the rising power-on threshold |
| sup_lo_ok | input | 1 | Supply above the falling power-on threshold |
| en | input | 1 | Enable request |
| ss_done | input | 1 | Soft-start ramp has finished |
| out_ok | input | 1 | Output inside the power-good window |
| uv_trip | input | 1 | Output below the under-voltage level |
| ov_trip | input | 1 | Output above the over-voltage level |
| temp_hot | input | 1 | Die above the upper temperature trip |
| temp_cool | input | 1 | Die below the lower temperature trip |
| oc_req | input | 1 | Over-current latch request |
| v_slewing | input | 1 | Commanded output-voltage transition in progress |
| conv_en | output | 1 | Converter switching permitted |
| pwr_good | output | 1 | Power-good, high means good |
| crowbar | output | 1 | Force low-side switch on |
| ss_restart | output | 1 | One-clock soft-start restart pulse |

## Verification
The hardest case to reach from the ports is the latched-fault state with the crowbar engaged. The fault must first be latched, and the bench does this by raising under-voltage after a transition flag has hidden it. Over-voltage is then applied on top of the latched fault. The bench also has to show that a latched fault survives a steady enable and clears only through an enable low-then-high sequence or a supply drop. To do this it counts restart pulses across each of those sequences. A pulse-count delta of exactly one on each re-entry proves that a single soft start happened.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_SOFT  = 3'd1,
    ST_RUN   = 3'd2,
    ST_FAULT = 3'd3,
    ST_HOT   = 3'd4
  } sup_state_t;

  // positions of the flags in the synchronized flag vector
  localparam int F_HI   = 0;
  localparam int F_LO   = 1;
  localparam int F_EN   = 2;
  localparam int F_SSD  = 3;
  localparam int F_WIN  = 4;
  localparam int F_UV   = 5;
  localparam int F_OV   = 6;
  localparam int F_HOT  = 7;
  localparam int F_COOL = 8;
  localparam int F_OC   = 9;
  localparam int F_VT   = 10;
  localparam int NUM_FLAGS = 11;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];

endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
  import sup_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] flags,
  output sup_state_t           state,
  output logic                 ss_restart
);

  sup_state_t state_n;
  logic pwr_ok_q, en_d;
  logic hi_s, lo_s, en_s, ssd_s, uv_s, hot_s, cool_s, oc_s, vt_s, en_rise;

  assign hi_s   = flags[F_HI];
  assign lo_s   = flags[F_LO];
  assign en_s   = flags[F_EN];
  assign ssd_s  = flags[F_SSD];
  assign uv_s   = flags[F_UV];
  assign hot_s  = flags[F_HOT];
  assign cool_s = flags[F_COOL];
  assign oc_s   = flags[F_OC];
  assign vt_s   = flags[F_VT];
  assign en_rise = en_s && !en_d;

  // supply hysteresis: set by the upper threshold, cleared below the lower one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_ok_q <= 1'b0;
      en_d     <= 1'b0;
    end else begin
      en_d <= en_s;
      if (hi_s)       pwr_ok_q <= 1'b1;
      else if (!lo_s) pwr_ok_q <= 1'b0;
    end
  end

  always_comb begin
    state_n = state;
    if (!pwr_ok_q) begin
      state_n = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:   if (en_s) state_n = hot_s ? ST_HOT : ST_SOFT;
        ST_SOFT: begin
          if (!en_s)      state_n = ST_OFF;
          else if (hot_s) state_n = ST_HOT;
          else if (oc_s)  state_n = ST_FAULT;
          else if (ssd_s) state_n = ST_RUN;
        end
        ST_RUN: begin
          if (!en_s)               state_n = ST_OFF;
          else if (hot_s)          state_n = ST_HOT;
          else if (oc_s)           state_n = ST_FAULT;
          else if (uv_s && !vt_s)  state_n = ST_FAULT;
        end
        ST_HOT: begin
          if (!en_s)                 state_n = ST_OFF;
          else if (cool_s && !hot_s) state_n = ST_SOFT;
        end
        ST_FAULT: if (en_rise) state_n = ST_OFF;
        default:  state_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_OFF;
      ss_restart <= 1'b0;
    end else begin
      state      <= state_n;
      ss_restart <= (state_n == ST_SOFT) && (state != ST_SOFT);
    end
  end

  // R2: loss of the supply always ends in the off state
  p_supply_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok_q |=> state == ST_OFF);

  // R6: an unblanked under-voltage in run latches the fault
  p_uv_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && pwr_ok_q && en_s && !hot_s && uv_s && !vt_s) |=> state == ST_FAULT);

  // R11: a latched fault holds without an enable rising edge or supply loss
  p_fault_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAULT && pwr_ok_q && !en_rise) |=> state == ST_FAULT);

  // R3: the restart pulse lasts one clock and marks soft start
  p_restart_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |-> (state == ST_SOFT) ##1 !ss_restart);

endmodule

// File: rtl/sup_drive.sv
module sup_drive
  import sup_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  sup_state_t           state,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic                 conv_en,
  output logic                 pwr_good,
  output logic                 crowbar
);

  logic ov_s, win_s, vt_s, crowbar_live;

  assign ov_s  = flags[F_OV];
  assign win_s = flags[F_WIN];
  assign vt_s  = flags[F_VT];

  // crowbar stays armed in soft start, run and latched fault
  assign crowbar_live = (state == ST_SOFT) || (state == ST_RUN) || (state == ST_FAULT);

  always_comb begin
    crowbar  = crowbar_live && ov_s;
    conv_en  = ((state == ST_SOFT) || (state == ST_RUN)) && !ov_s;
    pwr_good = (state == ST_RUN) && !ov_s && (win_s || vt_s);
  end

  // R7: crowbar and switching never overlap
  p_crowbar_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    crowbar |-> !conv_en && !pwr_good);

  // R4: power-good only from the run state
  p_pgood_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> state == ST_RUN);

  // R1/R10: no switching outside soft start and run
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAULT || state == ST_HOT || state == ST_OFF) |-> !conv_en);

endmodule

// File: rtl/core_supervisor.sv
module core_supervisor
  import sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_hi_ok,
  input  logic sup_lo_ok,
  input  logic en,
  input  logic ss_done,
  input  logic out_ok,
  input  logic uv_trip,
  input  logic ov_trip,
  input  logic temp_hot,
  input  logic temp_cool,
  input  logic oc_req,
  input  logic v_slewing,
  output logic conv_en,
  output logic pwr_good,
  output logic crowbar,
  output logic ss_restart
);

  logic [NUM_FLAGS-1:0] raw_flags, sync_flags;
  sup_state_t state;

  always_comb begin
    raw_flags         = '0;
    raw_flags[F_HI]   = sup_hi_ok;
    raw_flags[F_LO]   = sup_lo_ok;
    raw_flags[F_EN]   = en;
    raw_flags[F_SSD]  = ss_done;
    raw_flags[F_WIN]  = out_ok;
    raw_flags[F_UV]   = uv_trip;
    raw_flags[F_OV]   = ov_trip;
    raw_flags[F_HOT]  = temp_hot;
    raw_flags[F_COOL] = temp_cool;
    raw_flags[F_OC]   = oc_req;
    raw_flags[F_VT]   = v_slewing;
  end

  sup_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(raw_flags), .d_out(sync_flags)
  );

  sup_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .flags(sync_flags),
    .state(state), .ss_restart(ss_restart)
  );

  sup_drive u_drive (
    .clk(clk), .rst_n(rst_n), .state(state), .flags(sync_flags),
    .conv_en(conv_en), .pwr_good(pwr_good), .crowbar(crowbar)
  );

endmodule

// File: tb/core_supervisor_bench.sv
module core_supervisor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_hi_ok = 0, sup_lo_ok = 0, en = 0, ss_done = 0, out_ok = 0;
  logic uv_trip = 0, ov_trip = 0, temp_hot = 0, temp_cool = 0, oc_req = 0, v_slewing = 0;
  logic conv_en, pwr_good, crowbar, ss_restart;

  int n_chk = 0, n_fail = 0, pulses = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_supervisor u_core_supervisor (
    .clk(clk), .rst_n(rst_n), .sup_hi_ok(sup_hi_ok), .sup_lo_ok(sup_lo_ok),
    .en(en), .ss_done(ss_done), .out_ok(out_ok), .uv_trip(uv_trip),
    .ov_trip(ov_trip), .temp_hot(temp_hot), .temp_cool(temp_cool),
    .oc_req(oc_req), .v_slewing(v_slewing), .conv_en(conv_en),
    .pwr_good(pwr_good), .crowbar(crowbar), .ss_restart(ss_restart)
  );

  always @(negedge clk) if (rst_n && ss_restart) pulses++;

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // outputs packed as conv_en,pwr_good,crowbar
  function automatic int outs();
    return {29'd0, conv_en, pwr_good, crowbar};
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {ss_restart, outs()}, 0);
    rst_n = 1'b1;
    settle();
    chk("R1 outputs after reset", outs(), 0);
    chk("R1 no pulse after reset", pulses, 0);
  endtask

  task automatic t_startup();
    en = 1; sup_lo_ok = 1; settle();
    chk("R2 no start on lower threshold only", outs(), 0);
    sup_hi_ok = 1; settle();
    chk("R3 soft start outputs", outs(), 3'b100);
    chk("R3 single restart pulse", pulses, 1);
    sup_hi_ok = 0; settle();
    chk("R2 keeps running above lower threshold", outs(), 3'b100);
    ss_done = 1; out_ok = 1; settle();
    chk("R4 power good in run", outs(), 3'b110);
    out_ok = 0; settle();
    chk("R4 power good falls outside window", outs(), 3'b100);
  endtask

  task automatic t_slew_and_uv();
    v_slewing = 1; settle();
    chk("R5 power good held in transition", outs(), 3'b110);
    uv_trip = 1; settle();
    chk("R6 under-voltage blanked in transition", outs(), 3'b110);
    v_slewing = 0; settle();
    chk("R6 under-voltage latches fault", outs(), 3'b000);
    uv_trip = 0; out_ok = 1; settle();
    chk("R6 fault stays latched", outs(), 3'b000);
  endtask

  task automatic t_fault_crowbar_and_clear();
    int p0;
    ov_trip = 1; settle();
    chk("R8 crowbar in latched fault", outs(), 3'b001);
    ov_trip = 0; settle();
    chk("R8 crowbar released in fault", outs(), 3'b000);
    repeat (20) @(negedge clk);
    chk("R11 steady enable keeps fault", outs(), 3'b000);
    p0 = pulses;
    en = 0; settle();
    en = 1; settle();
    chk("R11 enable cycle clears fault", outs(), 3'b110);
    chk("R11 one soft start after enable cycle", pulses - p0, 1);
  endtask

  task automatic t_overvoltage();
    ov_trip = 1; settle();
    chk("R7 crowbar in run", outs(), 3'b001);
    ov_trip = 0; settle();
    chk("R7 crowbar releases without latch", outs(), 3'b110);
  endtask

  task automatic t_overtemp();
    int p0;
    p0 = pulses;
    temp_hot = 1; settle();
    chk("R9 over-temperature shuts down", outs(), 3'b000);
    temp_hot = 0; settle();
    chk("R9 waits for lower trip point", outs(), 3'b000);
    temp_cool = 1; settle();
    chk("R9 resumes after cooling", outs(), 3'b110);
    chk("R9 full soft start on resume", pulses - p0, 1);
    temp_cool = 0;
  endtask

  task automatic t_overcurrent_and_supply();
    int p0;
    oc_req = 1; settle();
    chk("R10 over-current latches", outs(), 3'b000);
    oc_req = 0; settle();
    chk("R10 latch holds after request drops", outs(), 3'b000);
    p0 = pulses;
    sup_lo_ok = 0; settle();
    chk("R2 below lower threshold stays off", outs(), 3'b000);
    sup_lo_ok = 1; sup_hi_ok = 1; settle();
    chk("R11 supply cycle clears fault", outs(), 3'b110);
    chk("R11 one soft start after supply cycle", pulses - p0, 1);
  endtask

  task automatic t_enable_drop();
    en = 0; settle();
    chk("R12 enable low stops converter", outs(), 3'b000);
    ss_done = 0; uv_trip = 1;
    en = 1; settle();
    chk("R12 enable restarts via soft start", outs(), 3'b100);
    chk("R6 under-voltage ignored in soft start", outs(), 3'b100);
    uv_trip = 0; ss_done = 1; settle();
    chk("R12 run after restart", outs(), 3'b110);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_startup();
    t_slew_and_uv();
    t_fault_crowbar_and_clear();
    t_overvoltage();
    t_overtemp();
    t_overcurrent_and_supply();
    t_enable_drop();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

endmodule